// File: doc/BRIEF.md
# Dual-Result Processor ALU

This block is the purely combinational arithmetic core of a small pipelined processor. Each cycle the surrounding pipeline presents an operation code, two data operands, a short immediate chunk and a flag that says whether this chunk continues an immediate already being built. The block returns two results. The first is the value normally written back to a general register or to the temporary register. The second result covers several needs. For most operations it passes the second operand through unchanged, which serves register swaps, store data, and the case where an add must leave the old register value in the temporary register. For multiply it carries the upper word of the double-width product. For address updates it carries the address that is handed to memory.

The operations are add and subtract with carry or borrow out, the three bitwise logic operations, three shifts, unsigned and signed multiply, load-immediate in chunks, post-increment and pre-decrement of an address. A zero flag reports whether the first result is zero.

Top module: `dual_out_alu`

## Requirements
- R1: `op` is 4 bits: ADD=0, SUB=1, AND=2, OR=3, XOR=4, SHL=5, SHR=6, SRA=7, MULU=8, MULS=9, LDI=10, PINC=11, PDEC=12. Codes 13 to 15 give `res1`=0, `res2`=`opnd_b` and `carry`=0.
- R2: ADD gives `res1`=A+B mod 2^32, and `carry` is the carry out of bit 31. SUB gives `res1`=A-B mod 2^32, and `carry` is 1 exactly when A<B unsigned (a borrow).
- R3: AND, OR and XOR give the bitwise combination of A and B on `res1`.
- R4: SHL, SHR and SRA shift A by `opnd_b[4:0]` only. SHL and SHR fill with zeros. SRA fills with A[31]. A shift amount of 0 returns A.
- R5: MULU and MULS form the full 64-bit product of A and B, treating the operands as unsigned or as two's complement respectively. The low word goes to `res1` and the high word goes to `res2`.
- R6: LDI with `imm_chain`=0 gives the 6-bit `imm` sign-extended to 32 bits. With `imm_chain`=1 it gives (A<<6)|imm.
- R7: PINC puts A+4 on `res1` and the unchanged A on `res2`.
- R8: PDEC puts A-4 on both `res1` and `res2`.
- R9: For every operation other than MULU, MULS, PINC and PDEC, `res2` equals `opnd_b`.
- R10: `zero` is 1 exactly when `res1` is 0. `carry` is 0 for every operation other than ADD and SUB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op | input | 4 | Operation code |
| opnd_a | input | 32 | First operand: address, shift source, immediate accumulator |
| opnd_b | input | 32 | Second operand: shift amount source, pass-through value |
| imm | input | 6 | Immediate chunk for LDI |
| imm_chain | input | 1 | 1 when this LDI continues a previous one |
| res1 | output | 32 | Primary result |
| res2 | output | 32 | Secondary result |
| carry | output | 1 | Carry (ADD) or borrow (SUB) |
| zero | output | 1 | `res1` equals zero |

## Verification
Every operation code, the unused ones included, is driven with random operands. Each result is compared against a behavioural model on every clock, which separates a wrong mux selection from a wrong datapath. Directed vectors target the cases that random operands rarely hit:
- the operand pairs that differ in value between signed and unsigned multiply;
- shift amounts above 31, which show whether the upper amount bits are masked;
- shift amounts of zero;
- equal operands and near-overflow operands for subtract, which locate the borrow;
- chained and fresh immediate chunks, with positive and negative sign bits.

// File: rtl/alu_pkg.sv
package alu_pkg;
   localparam int OP_W = 4;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 4'd0,
      OP_SUB  = 4'd1,
      OP_AND  = 4'd2,
      OP_OR   = 4'd3,
      OP_XOR  = 4'd4,
      OP_SHL  = 4'd5,
      OP_SHR  = 4'd6,
      OP_SRA  = 4'd7,
      OP_MULU = 4'd8,
      OP_MULS = 4'd9,
      OP_LDI  = 4'd10,
      OP_PINC = 4'd11,
      OP_PDEC = 4'd12
   } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W    = 32,
   parameter int STEP = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         subtract,
   output logic [W-1:0] sum,
   output logic         cy,
   output logic [W-1:0] a_up,
   output logic [W-1:0] a_down
);
   logic [W:0] wide;
   logic [W-1:0] b_eff;

   assign b_eff = subtract ? ~b : b;
   assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, subtract};
   assign sum   = wide[W-1:0];
   // borrow is the inverse of the carry out when subtracting
   assign cy    = subtract ? ~wide[W] : wide[W];

   assign a_up   = a + W'(STEP);
   assign a_down = a - W'(STEP);
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int W = 32,
   localparam int SH_W = $clog2(W)
) (
   input  logic [W-1:0]    a,
   input  logic [SH_W-1:0] amt,
   input  logic            left,
   input  logic            arith,
   output logic [W-1:0]    y
);
   logic [SH_W:0][W-1:0] stg;
   logic [W-1:0]         fin;
   logic                 fill;

   assign fill = arith & ~left & a[W-1];

   // a left shift is a right shift of the bit-reversed word
   for (genvar i = 0; i < W; i++) begin : g_rev_in
      assign stg[0][i] = left ? a[W-1-i] : a[i];
   end

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int SHV = 1 << s;
      assign stg[s+1] = amt[s] ? {{SHV{fill}}, stg[s][W-1:SHV]} : stg[s];
   end

   assign fin = stg[SH_W];

   for (genvar i = 0; i < W; i++) begin : g_rev_out
      assign y[i] = left ? fin[W-1-i] : fin[i];
   end
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         signed_mode,
   output logic [W-1:0] lo,
   output logic [W-1:0] hi
);
   logic [2*W-1:0] ax, bx, prod;
   logic           ea, eb;

   assign ea   = signed_mode & a[W-1];
   assign eb   = signed_mode & b[W-1];
   // product of the extended operands, taken modulo 2^(2W)
   assign ax   = {{W{ea}}, a};
   assign bx   = {{W{eb}}, b};
   assign prod = ax * bx;
   assign lo   = prod[W-1:0];
   assign hi   = prod[2*W-1:W];
endmodule

// File: rtl/alu_imm.sv
module alu_imm #(
   parameter int W     = 32,
   parameter int IMM_W = 6
) (
   input  logic [W-IMM_W-1:0] acc_lo,
   input  logic [IMM_W-1:0]   imm,
   input  logic               chain,
   output logic [W-1:0]       y
);
   logic [W-1:0] fresh, joined;

   assign fresh  = {{(W-IMM_W){imm[IMM_W-1]}}, imm};
   assign joined = {acc_lo, imm};
   assign y      = chain ? joined : fresh;
endmodule

// File: rtl/dual_out_alu.sv
module dual_out_alu
   import alu_pkg::*;
#(
   parameter int W     = 32,
   parameter int IMM_W = 6,
   parameter int STEP  = 4,
   localparam int SH_W = $clog2(W)
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    opnd_a,
   input  logic [W-1:0]    opnd_b,
   input  logic [IMM_W-1:0] imm,
   input  logic            imm_chain,
   output logic [W-1:0]    res1,
   output logic [W-1:0]    res2,
   output logic            carry,
   output logic            zero
);
   if ((W & (W - 1)) != 0) begin : g_bad_width
      $error("dual_out_alu: W must be a power of two");
   end
   if (W < 2 * IMM_W) begin : g_bad_imm
      $error("dual_out_alu: W must hold at least two immediate chunks");
   end
   if (STEP <= 0 || STEP >= W) begin : g_bad_step
      $error("dual_out_alu: STEP out of range");
   end

   logic [W-1:0] as_sum, as_up, as_down, sh_y, mul_lo, mul_hi, imm_y;
   logic         as_cy;
   logic         is_sub, sh_left, sh_arith, mul_signed;

   assign is_sub     = (op == OP_SUB);
   assign sh_left    = (op == OP_SHL);
   assign sh_arith   = (op == OP_SRA);
   assign mul_signed = (op == OP_MULS);

   alu_addsub #(.W(W), .STEP(STEP)) u_addsub (
      .a(opnd_a), .b(opnd_b), .subtract(is_sub),
      .sum(as_sum), .cy(as_cy), .a_up(as_up), .a_down(as_down)
   );

   alu_shift #(.W(W)) u_shift (
      .a(opnd_a), .amt(opnd_b[SH_W-1:0]), .left(sh_left),
      .arith(sh_arith), .y(sh_y)
   );

   alu_mul #(.W(W)) u_mul (
      .a(opnd_a), .b(opnd_b), .signed_mode(mul_signed),
      .lo(mul_lo), .hi(mul_hi)
   );

   alu_imm #(.W(W), .IMM_W(IMM_W)) u_imm (
      .acc_lo(opnd_a[W-IMM_W-1:0]), .imm(imm), .chain(imm_chain), .y(imm_y)
   );

   always_comb begin
      res1  = '0;
      res2  = opnd_b;
      carry = 1'b0;
      case (op)
         OP_ADD, OP_SUB: begin
            res1  = as_sum;
            carry = as_cy;
         end
         OP_AND:  res1 = opnd_a & opnd_b;
         OP_OR:   res1 = opnd_a | opnd_b;
         OP_XOR:  res1 = opnd_a ^ opnd_b;
         OP_SHL, OP_SHR, OP_SRA: res1 = sh_y;
         OP_MULU, OP_MULS: begin
            res1 = mul_lo;
            res2 = mul_hi;
         end
         OP_LDI:  res1 = imm_y;
         OP_PINC: begin
            res1 = as_up;
            res2 = opnd_a;
         end
         OP_PDEC: begin
            res1 = as_down;
            res2 = as_down;
         end
         default: ;
      endcase
   end

   assign zero = (res1 == '0);

   always_comb begin
      a_r8_pdec_same: assert (op != OP_PDEC || res1 == res2)
         else $error("R8: PDEC results differ");
      a_r7_pinc_gap: assert (op != OP_PINC || (res1 - res2) == W'(STEP))
         else $error("R7: PINC results not one step apart");
      a_r4_zero_amount: assert (!(op inside {OP_SHL, OP_SHR, OP_SRA}) ||
                                opnd_b[SH_W-1:0] != '0 || res1 == opnd_a)
         else $error("R4: zero shift changed operand");
      a_r6_fresh_sext: assert (op != OP_LDI || imm_chain ||
                               res1[W-1:IMM_W-1] == '0 || (&res1[W-1:IMM_W-1]))
         else $error("R6: fresh immediate not sign-extended");
      a_r9_passthrough: assert ((op inside {OP_MULU, OP_MULS, OP_PINC, OP_PDEC}) ||
                                res2 == opnd_b)
         else $error("R9: second result not operand B");
      a_r10_carry_idle: assert (op == OP_ADD || op == OP_SUB || !carry)
         else $error("R10: carry outside add/sub");
   end
endmodule

// File: tb/tb_dual_out_alu.sv
module tb_dual_out_alu;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  op = '0;
   logic [31:0] opnd_a = '0, opnd_b = '0;
   logic [5:0]  imm = '0;
   logic        imm_chain = 1'b0;
   logic [31:0] res1, res2;
   logic        carry, zero;

   int tests = 0;
   int fails = 0;
   bit done = 0;

   always #10 clk = ~clk;

   dual_out_alu dut (
      .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b), .imm(imm),
      .imm_chain(imm_chain), .res1(res1), .res2(res2),
      .carry(carry), .zero(zero)
   );

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'd0, 4'd1:       return "R2";
         4'd2, 4'd3, 4'd4: return "R3";
         4'd5, 4'd6, 4'd7: return "R4";
         4'd8, 4'd9:       return "R5";
         4'd10:            return "R6";
         4'd11:            return "R7";
         4'd12:            return "R8";
         default:          return "R1";
      endcase
   endfunction

   task automatic model(input logic [3:0] o, input logic [31:0] a, b,
                        input logic [5:0] im, input logic ch,
                        output logic [31:0] e1, e2, output logic ec, ez);
      logic [32:0] s33;
      longint unsigned pu;
      longint ps;
      e1 = 32'd0; e2 = b; ec = 1'b0;
      case (o)
         4'd0: begin s33 = {1'b0, a} + {1'b0, b}; e1 = s33[31:0]; ec = s33[32]; end
         4'd1: begin e1 = a - b; ec = (a < b); end
         4'd2: e1 = a & b;
         4'd3: e1 = a | b;
         4'd4: e1 = a ^ b;
         4'd5: e1 = a << b[4:0];
         4'd6: e1 = a >> b[4:0];
         4'd7: e1 = $unsigned($signed(a) >>> b[4:0]);
         4'd8: begin pu = {32'd0, a} * {32'd0, b}; e1 = pu[31:0]; e2 = pu[63:32]; end
         4'd9: begin
            ps = longint'($signed(a)) * longint'($signed(b));
            e1 = ps[31:0]; e2 = ps[63:32];
         end
         4'd10: e1 = ch ? ((a << 6) | {26'd0, im}) : {{26{im[5]}}, im};
         4'd11: begin e1 = a + 32'd4; e2 = a; end
         4'd12: begin e1 = a - 32'd4; e2 = a - 32'd4; end
         default: ;
      endcase
      ez = (e1 == 32'd0);
   endtask

   task automatic run(input logic [3:0] o, input logic [31:0] a, b,
                      input logic [5:0] im, input logic ch, input string tag);
      logic [31:0] e1, e2;
      logic ec, ez;
      @(negedge clk);
      op = o; opnd_a = a; opnd_b = b; imm = im; imm_chain = ch;
      model(o, a, b, im, ch, e1, e2, ec, ez);
      @(posedge clk);
      #2;
      tests++;
      if ({res1, res2, carry, zero} !== {e1, e2, ec, ez}) begin
         fails++;
         $display("FAIL %s op=%0d a=%h b=%h: actual res1=%h res2=%h c=%b z=%b expected res1=%h res2=%h c=%b z=%b",
                  tag, o, a, b, res1, res2, carry, zero, e1, e2, ec, ez);
      end
   endtask

   initial begin
      #(20 * 190000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (2) @(posedge clk);
      #2;
      tests++;   // R10: all-zero inputs, reset state
      if (res1 !== 0 || res2 !== 0 || carry !== 0 || zero !== 1) begin
         fails++;
         $display("FAIL R10 idle: actual %h %h %b %b expected 0 0 0 1", res1, res2, carry, zero);
      end
      rst = 1'b0;

      // R2 carry and borrow corners, R10 zero flag
      run(4'd0, 32'hFFFF_FFFF, 32'd1, 6'd0, 0, "R2 add wrap R10");
      run(4'd0, 32'h7FFF_FFFF, 32'd1, 6'd0, 0, "R2 add no carry");
      run(4'd1, 32'd5, 32'd5, 6'd0, 0, "R2 sub equal R10");
      run(4'd1, 32'd4, 32'd5, 6'd0, 0, "R2 sub borrow");
      run(4'd1, 32'h8000_0000, 32'd1, 6'd0, 0, "R2 sub no borrow");
      // R4 masking and zero amounts
      run(4'd5, 32'h0000_0001, 32'd37, 6'd0, 0, "R4 shl masked");
      run(4'd7, 32'h8000_0000, 32'd31, 6'd0, 0, "R4 sra full");
      run(4'd6, 32'h8000_0000, 32'd31, 6'd0, 0, "R4 shr full");
      run(4'd7, 32'h8123_4567, 32'd32, 6'd0, 0, "R4 sra amount zero");
      // R5 extreme multiplies
      run(4'd8, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd0, 0, "R5 mulu max");
      run(4'd9, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 6'd0, 0, "R5 muls -1");
      run(4'd9, 32'h8000_0000, 32'h8000_0000, 6'd0, 0, "R5 muls min");
      run(4'd9, 32'h8000_0000, 32'h7FFF_FFFF, 6'd0, 0, "R5 muls mixed");
      run(4'd8, 32'h8000_0000, 32'h7FFF_FFFF, 6'd0, 0, "R5 mulu mixed");
      // R6 immediate chains
      run(4'd10, 32'h0, 32'h55, 6'h20, 0, "R6 fresh negative");
      run(4'd10, 32'h0, 32'h55, 6'h1F, 0, "R6 fresh positive");
      run(4'd10, 32'hFFFF_FFE0, 32'h0, 6'h15, 1, "R6 chained");
      run(4'd10, 32'h0000_0003, 32'h0, 6'h3F, 1, "R6 chained positive");
      // R7 / R8 address updates
      run(4'd11, 32'hFFFF_FFFC, 32'h1, 6'd0, 0, "R7 pinc wrap");
      run(4'd12, 32'h0000_0004, 32'h1, 6'd0, 0, "R8 pdec to zero R10");
      run(4'd12, 32'h0000_0000, 32'h1, 6'd0, 0, "R8 pdec wrap");
      // R1 unused codes, R9 pass-through
      run(4'd13, 32'h1234_5678, 32'hCAFE_F00D, 6'd1, 0, "R1 unused R9");
      run(4'd15, 32'h1234_5678, 32'h0, 6'd1, 1, "R1 unused");

      // random sweep over every code (R9 pass-through checked within)
      for (int o = 0; o < 16; o++) begin
         for (int k = 0; k < 150; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (k % 5 == 0) rb = rb & 32'h3F;
            run(o[3:0], ra, rb, 6'($urandom), 1'($urandom), req_of(o[3:0]));
         end
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule